// File: doc/BRIEF.md
# Receive Descriptor Chain Controller

This block is the receive half of one DMA channel. It walks a linked list of descriptors in memory. Each descriptor is three 32-bit words: a control word, a buffer pointer and a next pointer. Software loads the 20-bit address of the first descriptor and pulses a start control. The block reads the three words over a single-beat memory port and validates them. It then writes each incoming peripheral byte into the buffer the descriptor describes.

A descriptor is finished when its buffer is full or when a byte marked last arrives. The block then writes the control word back to memory with the received length and the ownership handed to the CPU, and follows the next pointer. A next pointer of zero ends the list. A restart control re-reads the next pointer of the current descriptor, so a descriptor appended while the channel was parked can be picked up.

The block keeps the current descriptor address and the two before it. It also captures the descriptor address at a successful end of frame and at a data error. Seven sticky event flags can each be masked, and a single interrupt output is the OR of the unmasked flags.

Top module: `rxd_chain_ctrl`

## Requirements
- R1: After reset `park` is 1, `s_ready` is 0 and all event flags are 0. A `ctl_start` pulse while parked loads the zero-extended `cfg_head_addr` as the current descriptor, clears `park` on the next cycle and issues a read of that address.
- R2: A `ctl_stop` pulse while working, or a `ch_reset` pulse in any state, returns the channel to the parked state on the next cycle.
- R3: A descriptor is read as three single-beat words at offsets 0, 4 and 8. Word 0 holds owner in bit 31 (1 = DMA), EOF in bit 30, length in bits 23:12 and buffer size in bits 11:0. Word 1 is the buffer address and word 2 is the next descriptor address, where 0 ends the list. `s_ready` is high only while the channel waits for a byte.
- R4: The n-th accepted byte of a descriptor (counting from 0) is written to buffer address + n. The write uses a word-aligned address, a one-hot byte enable and the byte copied into all four lanes.
- R5: A descriptor completes when its buffer is full or a byte with `s_last` arrives. Word 0 is then written back with owner 0, EOF set only for a last byte, the received length and the unchanged size. After the write-back the done flag (bit 0) is raised. On EOF without error the success-EOF flag (bit 1) is raised and `eof_ok_addr` captures the descriptor address.
- R6: After write-back the channel moves to a nonzero next pointer and fetches it. With a zero next pointer and EOF it parks.
- R7: With a zero next pointer, a full buffer and no EOF, the channel waits. A further byte offered then raises descriptor-empty (bit 4) and parks without accepting the byte.
- R8: With `cfg_owner_chk` set, a descriptor whose owner bit is 0 raises descriptor-error (bit 3) and parks. With it clear, the same descriptor is accepted.
- R9: A buffer pointer that is unaligned or outside [WIN_LO, WIN_HI), a nonzero next pointer that is unaligned or outside that window, or a buffer size of 0 raises descriptor-error and parks.
- R10: A byte with `s_err` raises error-EOF (bit 2) and `eof_err_addr` captures the current descriptor. With `cfg_auto_ret` = 1 there is no write-back: the same descriptor is fetched again from offset 0. With `cfg_auto_ret` = 0 the descriptor is written back with EOF set and the chain advances.
- R11: A `ctl_restart` pulse while parked re-reads the next pointer of the current descriptor and ignores `cfg_head_addr`. If that pointer is nonzero and valid the channel moves to it; if it is zero the channel stays parked.
- R12: Each descriptor load shifts the history: `dscr_prev2` takes `dscr_prev1`, `dscr_prev1` takes `dscr_cur`, and `dscr_cur` takes the new address.
- R13: Event flags are sticky until a 1 is written to the matching `irq_clr` bit; a set in the same cycle wins. `irq_status` = `irq_raw` AND `irq_ena`, and `irq` is the OR of `irq_status`.
- R14: A byte offered while parked raises overflow (bit 5). A `ch_reset` pulse while working raises underflow (bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_reset | input | 1 | Channel reset pulse: state machine and byte counter return to idle |
| cfg_head_addr | input | HEAD_W | Low bits of the first descriptor address |
| ctl_start | input | 1 | Start pulse |
| ctl_stop | input | 1 | Stop pulse |
| ctl_restart | input | 1 | Restart pulse |
| cfg_owner_chk | input | 1 | Enable the owner check |
| cfg_auto_ret | input | 1 | Re-fetch the current descriptor on data error |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| s_valid | input | 1 | Peripheral byte valid |
| s_data | input | 8 | Peripheral byte |
| s_last | input | 1 | Byte ends the frame |
| s_err | input | 1 | Byte carries a data error |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| park | output | 1 | Channel idle |
| dscr_cur | output | 32 | Current descriptor address |
| dscr_prev1 | output | 32 | Previous descriptor address |
| dscr_prev2 | output | 32 | Descriptor address before the previous one |
| eof_ok_addr | output | 32 | Descriptor address at last successful EOF |
| eof_err_addr | output | 32 | Descriptor address at last data error |
| irq_ena | input | 7 | Event enables |
| irq_clr | input | 7 | Write-one-to-clear pulses |
| irq_raw | output | 7 | Sticky event flags |
| irq_status | output | 7 | Masked event flags |
| irq | output | 1 | Interrupt |

## Verification
A control pulse takes effect at the next edge. `park`, `s_ready` and the first read address therefore change one cycle after start, stop or channel reset, and the bench samples them at the falling edge after that. Event flags, captured addresses and history registers change at the edge that completes the write-back or the offending read. They reach `irq_raw` one cycle after that acknowledge, while `irq_status` and `irq` follow `irq_raw` in the same cycle. Memory reads and writes take a variable number of cycles, so the bench waits for a port-level milestone (parking, or `s_ready` rising) and only then compares results, all sampled at falling edges.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 12;
    localparam int EVT_N  = 7;

    // event bit positions
    localparam int EV_DONE  = 0;
    localparam int EV_SUC   = 1;
    localparam int EV_ERR   = 2;
    localparam int EV_DSCR  = 3;
    localparam int EV_EMPTY = 4;
    localparam int EV_OVF   = 5;
    localparam int EV_UDF   = 6;

    // control word of a descriptor
    typedef struct packed {
        logic             owner;
        logic             eof;
        logic [5:0]       rsvd;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] size;
    } dw0_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_CHK,
        ST_RECV, ST_WR,  ST_WB,  ST_DRY, ST_LINK
    } walk_st_e;

    function automatic logic ptr_ok(input logic [WORD_W-1:0] a,
                                    input logic [WORD_W-1:0] lo,
                                    input logic [WORD_W-1:0] hi);
        return (a[1:0] == 2'b00) && (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/rxd_event_regs.sv
module rxd_event_regs #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ena,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw,
    output logic [N-1:0] status,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         raw[i] <= 1'b0;
            else if (set[i]) raw[i] <= 1'b1;
            else if (clr[i]) raw[i] <= 1'b0;
        end
    end

    assign status = raw & ena;
    assign irq    = |status;
endmodule

// File: rtl/rxd_addr_history.sv
module rxd_addr_history #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] new_addr,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] prev1,
    output logic [AW-1:0] prev2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            prev1 <= '0;
            prev2 <= '0;
        end else if (load) begin
            prev2 <= prev1;
            prev1 <= cur;
            cur   <= new_addr;
        end
    end
endmodule

// File: rtl/rxd_walker.sv
module rxd_walker
    import rxd_pkg::*;
#(
    parameter int              HEAD_W = 20,
    parameter logic [WORD_W-1:0] WIN_LO = 32'h0000_0040,
    parameter logic [WORD_W-1:0] WIN_HI = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_reset,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_restart,
    input  logic              cfg_owner_chk,
    input  logic              cfg_auto_ret,
    input  logic [HEAD_W-1:0] cfg_head,
    input  logic [WORD_W-1:0] cur_addr,
    output logic              hist_load,
    output logic [WORD_W-1:0] hist_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic              park,
    output logic [WORD_W-1:0] suc_addr,
    output logic [WORD_W-1:0] err_addr,
    output logic [EVT_N-1:0]  ev_set
);
    walk_st_e          st;
    logic              w0_owner;
    logic [LEN_W-1:0]  w0_size;
    logic [WORD_W-1:0] bufp, nxtp;
    logic [LEN_W-1:0]  cnt;
    logic [7:0]        pbyte;
    logic              plast, perr;
    logic              fin_eof, fin_err;

    logic [LEN_W-1:0]  cnt_nx;
    logic [WORD_W-1:0] wa;
    logic              running, chk_bad, wr_done, wb_done;
    logic              link_ok, link_bad;
    dw0_t              wbw;

    assign cnt_nx  = cnt + 1'b1;
    assign wa      = bufp + WORD_W'(cnt);
    assign running = !ch_reset && !(ctl_stop && st != ST_IDLE);
    assign chk_bad = (cfg_owner_chk && !w0_owner) || (w0_size == '0) ||
                     !ptr_ok(bufp, WIN_LO, WIN_HI) ||
                     ((nxtp != '0) && !ptr_ok(nxtp, WIN_LO, WIN_HI));
    assign wr_done = (st == ST_WR) && mem_ack;
    assign wb_done = (st == ST_WB) && mem_ack;
    assign link_ok  = (st == ST_LINK) && mem_ack && (mem_rdata != '0) &&
                      ptr_ok(mem_rdata, WIN_LO, WIN_HI);
    assign link_bad = (st == ST_LINK) && mem_ack && (mem_rdata != '0) &&
                      !ptr_ok(mem_rdata, WIN_LO, WIN_HI);

    assign park    = (st == ST_IDLE);
    assign s_ready = (st == ST_RECV);

    always_comb begin
        wbw       = '0;
        wbw.owner = 1'b0;
        wbw.eof   = fin_eof;
        wbw.len   = cnt;
        wbw.size  = w0_size;
    end

    // memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_be    = 4'h0;
        mem_wdata = '0;
        unique case (st)
            ST_RD0:  mem_req = 1'b1;
            ST_RD1:  begin mem_req = 1'b1; mem_addr = cur_addr + 32'd4; end
            ST_RD2,
            ST_LINK: begin mem_req = 1'b1; mem_addr = cur_addr + 32'd8; end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {wa[WORD_W-1:2], 2'b00};
                mem_be    = 4'b0001 << wa[1:0];
                mem_wdata = {4{pbyte}};
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = wbw;
            end
            default: ;
        endcase
    end

    // descriptor loads into the history
    always_comb begin
        hist_load = running && (((st == ST_IDLE) && ctl_start) ||
                                (wb_done && (nxtp != '0)) || link_ok);
        if (st == ST_IDLE)      hist_addr = WORD_W'(cfg_head);
        else if (st == ST_LINK) hist_addr = mem_rdata;
        else                    hist_addr = nxtp;
    end

    // events
    always_comb begin
        ev_set           = '0;
        ev_set[EV_DONE]  = running && wb_done;
        ev_set[EV_SUC]   = running && wb_done && fin_eof && !fin_err;
        ev_set[EV_ERR]   = running && wr_done && perr;
        ev_set[EV_DSCR]  = running && (((st == ST_CHK) && chk_bad) || link_bad);
        ev_set[EV_EMPTY] = running && (st == ST_DRY) && s_valid;
        ev_set[EV_OVF]   = (st == ST_IDLE) && s_valid;
        ev_set[EV_UDF]   = ch_reset && (st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            w0_owner <= 1'b0;
            w0_size  <= '0;
            bufp     <= '0;
            nxtp     <= '0;
            cnt      <= '0;
            pbyte    <= '0;
            plast    <= 1'b0;
            perr     <= 1'b0;
            fin_eof  <= 1'b0;
            fin_err  <= 1'b0;
            suc_addr <= '0;
            err_addr <= '0;
        end else begin
            if (ev_set[EV_SUC]) suc_addr <= cur_addr;
            if (ev_set[EV_ERR]) err_addr <= cur_addr;
            if (ch_reset) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else if (ctl_stop && st != ST_IDLE) begin
                st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (ctl_start)        st <= ST_RD0;
                        else if (ctl_restart) st <= ST_LINK;
                    end
                    ST_RD0: if (mem_ack) begin
                        w0_owner <= mem_rdata[31];
                        w0_size  <= mem_rdata[LEN_W-1:0];
                        st       <= ST_RD1;
                    end
                    ST_RD1: if (mem_ack) begin
                        bufp <= mem_rdata;
                        st   <= ST_RD2;
                    end
                    ST_RD2: if (mem_ack) begin
                        nxtp <= mem_rdata;
                        st   <= ST_CHK;
                    end
                    ST_CHK: begin
                        if (chk_bad) st <= ST_IDLE;
                        else begin
                            cnt <= '0;
                            st  <= ST_RECV;
                        end
                    end
                    ST_RECV: if (s_valid) begin
                        pbyte <= s_data;
                        plast <= s_last;
                        perr  <= s_err;
                        st    <= ST_WR;
                    end
                    ST_WR: if (mem_ack) begin
                        if (perr && cfg_auto_ret) begin
                            cnt <= '0;
                            st  <= ST_RD0;
                        end else begin
                            cnt     <= cnt_nx;
                            fin_eof <= plast || perr;
                            fin_err <= perr;
                            st      <= (plast || perr || cnt_nx == w0_size) ?
                                       ST_WB : ST_RECV;
                        end
                    end
                    ST_WB: if (mem_ack) begin
                        if (nxtp != '0)   st <= ST_RD0;
                        else if (fin_eof) st <= ST_IDLE;
                        else              st <= ST_DRY;
                    end
                    ST_DRY: if (s_valid) st <= ST_IDLE;
                    ST_LINK: if (mem_ack) st <= link_ok ? ST_RD0 : ST_IDLE;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxd_chain_ctrl.sv
module rxd_chain_ctrl
    import rxd_pkg::*;
#(
    parameter int                HEAD_W = 20,
    parameter logic [WORD_W-1:0] WIN_LO = 32'h0000_0040,
    parameter logic [WORD_W-1:0] WIN_HI = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_reset,
    input  logic [HEAD_W-1:0] cfg_head_addr,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_restart,
    input  logic              cfg_owner_chk,
    input  logic              cfg_auto_ret,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic              park,
    output logic [WORD_W-1:0] dscr_cur,
    output logic [WORD_W-1:0] dscr_prev1,
    output logic [WORD_W-1:0] dscr_prev2,
    output logic [WORD_W-1:0] eof_ok_addr,
    output logic [WORD_W-1:0] eof_err_addr,
    input  logic [EVT_N-1:0]  irq_ena,
    input  logic [EVT_N-1:0]  irq_clr,
    output logic [EVT_N-1:0]  irq_raw,
    output logic [EVT_N-1:0]  irq_status,
    output logic              irq
);
    logic              hist_load;
    logic [WORD_W-1:0] hist_addr;
    logic [EVT_N-1:0]  ev_set;

    rxd_walker #(.HEAD_W(HEAD_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_walk (
        .clk(clk), .rst(rst), .ch_reset(ch_reset),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_restart(ctl_restart),
        .cfg_owner_chk(cfg_owner_chk), .cfg_auto_ret(cfg_auto_ret),
        .cfg_head(cfg_head_addr), .cur_addr(dscr_cur),
        .hist_load(hist_load), .hist_addr(hist_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err),
        .s_ready(s_ready), .park(park),
        .suc_addr(eof_ok_addr), .err_addr(eof_err_addr), .ev_set(ev_set)
    );

    rxd_addr_history #(.AW(WORD_W)) u_hist (
        .clk(clk), .rst(rst), .load(hist_load), .new_addr(hist_addr),
        .cur(dscr_cur), .prev1(dscr_prev1), .prev2(dscr_prev2)
    );

    rxd_event_regs #(.N(EVT_N)) u_evt (
        .clk(clk), .rst(rst), .set(ev_set), .ena(irq_ena), .clr(irq_clr),
        .raw(irq_raw), .status(irq_status), .irq(irq)
    );
endmodule

// File: rtl/rxd_chain_sva.sv
module rxd_chain_sva (
    input logic        clk,
    input logic        rst,
    input logic        ch_reset,
    input logic        ctl_start,
    input logic        ctl_stop,
    input logic        park,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        s_valid,
    input logic        s_ready,
    input logic [6:0]  irq_raw,
    input logic [6:0]  irq_clr
);
    p_park_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        park |-> !mem_req);

    p_start_runs_r1: assert property (@(posedge clk) disable iff (rst)
        (park && ctl_start && !ch_reset) |=> !park);

    p_stop_parks_r2: assert property (@(posedge clk) disable iff (rst)
        ((ctl_stop && !park) || ch_reset) |=> park);

    p_ready_wait_r3: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (!park && !mem_req));

    p_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_wb_owner_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[31]);

    p_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((irq_raw & $past(irq_raw & ~irq_clr)) == $past(irq_raw & ~irq_clr)));

    p_ovf_r14: assert property (@(posedge clk) disable iff (rst)
        (park && s_valid) |=> irq_raw[5]);
endmodule

bind rxd_chain_ctrl rxd_chain_sva u_sva (
    .clk(clk), .rst(rst), .ch_reset(ch_reset), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .park(park), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .irq_raw(irq_raw), .irq_clr(irq_clr)
);

// File: tb/tb_rxd_chain_ctrl.sv
module tb_rxd_chain_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ch_reset = 1'b0;
    logic [19:0] cfg_head_addr = '0;
    logic        ctl_start = 1'b0, ctl_stop = 1'b0, ctl_restart = 1'b0;
    logic        cfg_owner_chk = 1'b0, cfg_auto_ret = 1'b1;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready, park, irq;
    logic [31:0] dscr_cur, dscr_prev1, dscr_prev2, eof_ok_addr, eof_err_addr;
    logic [6:0]  irq_ena = '0, irq_clr = '0, irq_raw, irq_status;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rxd_chain_ctrl dut (.*);

    // memory model with a backdoor for the bench
    logic [31:0] mem [256];
    logic        bd_we = 1'b0;
    logic [31:0] bd_addr = '0, bd_data = '0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (bd_we) mem[bd_addr[9:2]] <= bd_data;
        else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    function automatic logic [31:0] w0(input logic own, input logic eof,
                                       input int len, input int size);
        return {own, eof, 6'b0, len[11:0], size[11:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_mem(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
        @(negedge clk); bd_we = 1'b0;
    endtask

    task automatic mk(input logic [31:0] a, input logic own, input int size,
                      input logic [31:0] bufa, input logic [31:0] nxt);
        wr_mem(a, w0(own, 1'b0, 0, size));
        wr_mem(a + 4, bufa);
        wr_mem(a + 8, nxt);
    endtask

    task automatic clear_all();
        @(negedge clk); irq_clr = 7'h7F;
        @(negedge clk); irq_clr = 7'h00;
    endtask

    task automatic pulse_start();
        @(negedge clk); ctl_start = 1'b1;
        @(negedge clk); ctl_start = 1'b0;
    endtask

    task automatic wait_park();
        int g = 0;
        @(negedge clk);
        while (!park && g < 500) begin @(negedge clk); g++; end
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!s_ready && g < 500) begin @(negedge clk); g++; end
    endtask

    task automatic push(input logic [7:0] d, input logic l, input logic e);
        int g = 0;
        @(negedge clk); s_valid = 1'b1; s_data = d; s_last = l; s_err = e;
        while (!s_ready && g < 500) begin @(negedge clk); g++; end
        @(negedge clk); s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_cur;
        logic [31:0] exp0, exp1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 park after reset", park, 1);
        chk("R1 ready after reset", s_ready, 0);
        chk("R13 raw after reset", irq_raw, 0);
        chk("R13 irq after reset", irq, 0);

        // single descriptor, EOF on third byte
        mk(32'h40, 1, 4, 32'h100, 0);
        wr_mem(32'h100, 0);
        cfg_head_addr = 20'h00040;
        pulse_start();
        chk("R1 park low after start", park, 0);
        chk("R1 first read address", {mem_req, mem_we, mem_addr}, {2'b10, 32'h40});
        push(8'hA1, 0, 0); push(8'hA2, 0, 0); push(8'hA3, 1, 0);
        wait_park();
        chk("R4 buffer bytes", mem[32'h100 >> 2], 32'h00A3A2A1);
        chk("R5 writeback word", mem[32'h40 >> 2], w0(0, 1, 3, 4));
        chk("R5 done and eof flags", irq_raw, 7'h03);
        chk("R5 eof address", eof_ok_addr, 32'h40);
        chk("R13 masked off", {irq_status, irq}, 0);
        @(negedge clk); irq_ena = 7'h02;
        @(negedge clk);
        chk("R13 masked status", {irq_status, irq}, {7'h02, 1'b1});
        irq_ena = 7'h00;
        last_cur = 32'h40;

        // R5 R6 R12 sweep of frame lengths over a two-descriptor chain
        for (int n = 1; n <= 6; n++) begin
            clear_all();
            mk(32'h50, 1, 3, 32'h140, 32'h60);
            mk(32'h60, 1, 3, 32'h180, 0);
            wr_mem(32'h140, 0); wr_mem(32'h180, 0);
            cfg_head_addr = 20'h00050;
            pulse_start();
            for (int k = 0; k < n; k++) push(8'(n * 16 + k), k == n - 1, 0);
            if (n <= 3) begin
                wait_ready();
                @(negedge clk); ctl_stop = 1'b1;
                @(negedge clk); ctl_stop = 1'b0;
                chk("R2 stop parks", park, 1);
            end
            wait_park();
            exp0 = 0; exp1 = 0;
            for (int k = 0; k < n; k++) begin
                if (k < 3) exp0[8*k +: 8] = 8'(n * 16 + k);
                else       exp1[8*(k-3) +: 8] = 8'(n * 16 + k);
            end
            chk("R4 first buffer", mem[32'h140 >> 2], exp0);
            chk("R4 second buffer", mem[32'h180 >> 2], exp1);
            chk("R5 first writeback", mem[32'h50 >> 2], w0(0, n <= 3, n < 3 ? n : 3, 3));
            chk("R6 second descriptor word", mem[32'h60 >> 2],
                n > 3 ? w0(0, 1, n - 3, 3) : w0(1, 0, 0, 3));
            chk("R5 eof address sweep", eof_ok_addr, n <= 3 ? 32'h50 : 32'h60);
            chk("R12 history", {dscr_cur, dscr_prev1}, {32'h60, 32'h50});
            chk("R12 oldest", dscr_prev2, last_cur);
            chk("R5 suc flag", irq_raw[1], 1);
            last_cur = 32'h60;
        end

        // R8 owner check
        clear_all();
        mk(32'h70, 0, 2, 32'h1C0, 0);
        cfg_owner_chk = 1'b1;
        cfg_head_addr = 20'h00070;
        pulse_start();
        wait_park();
        chk("R8 owner error flag", irq_raw, 7'h08);
        cfg_owner_chk = 1'b0;
        clear_all();
        pulse_start();
        wait_ready();
        chk("R8 accepted without check", {s_ready, irq_raw[3]}, 2'b10);
        push(8'h55, 1, 0);
        wait_park();

        // R9 bad pointers and zero size
        for (int v = 0; v < 4; v++) begin
            clear_all();
            case (v)
                0: mk(32'h70, 1, 2, 32'h1C2, 0);
                1: mk(32'h70, 1, 2, 32'h800, 0);
                2: mk(32'h70, 1, 2, 32'h1C0, 32'h404);
                default: mk(32'h70, 1, 0, 32'h1C0, 0);
            endcase
            pulse_start();
            wait_park();
            chk("R9 descriptor error", {irq_raw[3], s_ready}, 2'b10);
        end

        // R10 auto-return on
        clear_all();
        cfg_auto_ret = 1'b1;
        mk(32'h40, 1, 4, 32'h100, 0);
        wr_mem(32'h100, 0);
        cfg_head_addr = 20'h00040;
        pulse_start();
        push(8'hA0, 0, 0);
        push(8'hB0, 0, 1);
        wait_ready();
        chk("R10 error flag no done", {irq_raw[2], irq_raw[0]}, 2'b10);
        chk("R10 error address", eof_err_addr, 32'h40);
        chk("R10 no writeback", mem[32'h40 >> 2], w0(1, 0, 0, 4));
        push(8'hC0, 1, 0);
        wait_park();
        chk("R10 restarted length", mem[32'h40 >> 2], w0(0, 1, 1, 4));
        chk("R10 buffer rewritten", mem[32'h100 >> 2][7:0], 8'hC0);

        // R10 auto-return off
        clear_all();
        cfg_auto_ret = 1'b0;
        mk(32'h40, 1, 4, 32'h100, 0);
        pulse_start();
        push(8'hD0, 0, 0);
        push(8'hE0, 0, 1);
        wait_park();
        chk("R10 writeback on error", mem[32'h40 >> 2], w0(0, 1, 2, 4));
        chk("R10 flags without auto-return", irq_raw[2:0], 3'b101);
        cfg_auto_ret = 1'b1;

        // R7 descriptor empty then R11 restart
        clear_all();
        mk(32'h50, 1, 2, 32'h140, 0);
        cfg_head_addr = 20'h00050;
        pulse_start();
        push(8'h01, 0, 0); push(8'h02, 0, 0);
        @(negedge clk); s_valid = 1'b1; s_data = 8'h03; s_last = 1'b1;
        wait_park();
        chk("R7 empty flag", irq_raw[4], 1);
        chk("R7 writeback without eof", mem[32'h50 >> 2], w0(0, 0, 2, 2));
        mk(32'h60, 1, 2, 32'h180, 0);
        wr_mem(32'h180, 0);
        wr_mem(32'h58, 32'h60);
        cfg_head_addr = 20'h00070;
        @(negedge clk); ctl_restart = 1'b1;
        @(negedge clk); ctl_restart = 1'b0;
        wait_ready();
        @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
        wait_park();
        chk("R11 appended writeback", mem[32'h60 >> 2], w0(0, 1, 1, 2));
        chk("R11 appended data", mem[32'h180 >> 2][7:0], 8'h03);
        chk("R11 history after restart", {dscr_cur, dscr_prev1}, {32'h60, 32'h50});

        // R13 selective clear
        clear_all();
        mk(32'h40, 1, 4, 32'h100, 0);
        cfg_head_addr = 20'h00040;
        pulse_start();
        push(8'h11, 1, 0);
        wait_park();
        @(negedge clk); irq_clr = 7'h02;
        @(negedge clk); irq_clr = 7'h00;
        chk("R13 clear one bit", irq_raw, 7'h01);
        irq_ena = 7'h7F;
        @(negedge clk);
        chk("R13 irq follows status", {irq_status, irq}, {7'h01, 1'b1});
        irq_ena = 7'h00;

        // R14 overflow while parked
        clear_all();
        @(negedge clk); s_valid = 1'b1; s_data = 8'h99;
        @(negedge clk); s_valid = 1'b0;
        chk("R14 overflow flag", irq_raw, 7'h20);

        // R14 underflow and R2 channel reset
        clear_all();
        mk(32'h40, 1, 4, 32'h100, 0);
        pulse_start();
        wait_ready();
        @(negedge clk); ch_reset = 1'b1;
        @(negedge clk); ch_reset = 1'b0;
        chk("R2 channel reset parks", park, 1);
        @(negedge clk);
        chk("R14 underflow flag", irq_raw, 7'h40);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule